// File: doc/BRIEF.md
# PHY Configuration Register Bank with Per-Bit Write Masks

This block holds the configuration state of a PHY behind a simple synchronous register bus. It has seven control registers and one read-only status register. Every write carries its own write-enable mask in the upper half of the data word. Software can therefore set or clear single control bits without first reading the register back.

One control register drives two PHY controls: an active-high power-on control and a DLL enable. Two completion flags come back from the PHY: calibration finished and DLL locked. They pass through a two-flop synchronizer and are then readable in the status register. Read data is registered. It appears one cycle after the read strobe and holds until the next read.

Top module: `phycfg_regbank`

## Requirements
- R1: After reset every control register reads 0, `pwr_on_o` and `dll_en_o` are 0, and `bus_rdata` is 0.
- R2: A write to a control register changes bit x (0..15) only when `bus_wdata[x+16]` is 1. The bit then takes `bus_wdata[x]`. Every other bit keeps its value.
- R3: Control registers 0..6 sit at byte addresses 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18. The status register sits at 0x20.
- R4: A read strobe in cycle n loads `bus_rdata` at the end of cycle n. A control register reads as its 16 stored bits with bits 31:16 zero. `bus_rdata` holds its value in cycles without a read strobe.
- R5: `pwr_on_o` is bit 0 and `dll_en_o` is bit 1 of the register at 0x18. Each takes its new value in the cycle after the write.
- R6: In the status word, bit 6 is calibration done and bit 5 is DLL ready (1 = complete), and all other bits are 0. An input change is seen by a read issued two or more cycles later, never by a read in the same cycle.
- R7: Writes to 0x20, to 0x1C, to addresses above 0x20 or to unaligned addresses change no register. Reads of such addresses other than 0x20 return 0.
- R8: A read and a write to the same register in one cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; [31:16] mask, [15:0] value |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| cal_done_i | input | 1 | Calibration complete flag from the PHY |
| dll_ready_i | input | 1 | DLL ready flag from the PHY |
| pwr_on_o | output | 1 | PHY power-on control (1 = on) |
| dll_en_o | output | 1 | DLL enable (1 = enabled) |

## Verification
A wrong mask decode changes a control bit that was not selected. The next read of that register shows the damage. When the register is the one at 0x18, the power or DLL output is already wrong in the cycle after the write. A decode that aliases an unmapped or status address onto a control register shows the same wrong value on its next read. The reference model checks every read and both control outputs on every cycle, so any such fault shows at the first read that touches the corrupted register. A synchronizer of the wrong depth shows in the read that follows an input change.

// File: rtl/phycfg_pkg.sv
package phycfg_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2
  } phycfg_sel_e;
endpackage

// File: rtl/phycfg_sync.sv
module phycfg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/phycfg_mreg.sv
module phycfg_mreg #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [2*HALF_W-1:0] wdata,
  output logic [HALF_W-1:0] q
);
  logic [HALF_W-1:0] mask;
  logic [HALF_W-1:0] val;

  assign mask = wdata[2*HALF_W-1:HALF_W];
  assign val  = wdata[HALF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= (q & ~mask) | (val & mask);
  end

  // R2: unmasked bits hold
  a_r2_unmasked_hold: assert property (@(posedge clk) disable iff (rst)
    we |=> ((q & ~$past(mask)) == ($past(q) & ~$past(mask))));
  // R2: masked bits take the written value
  a_r2_masked_take: assert property (@(posedge clk) disable iff (rst)
    we |=> ((q & $past(mask)) == ($past(val) & $past(mask))));
endmodule

// File: rtl/phycfg_decode.sv
module phycfg_decode
  import phycfg_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                NUM_CTRL  = 7,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h20
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_CTRL-1:0] ctrl_hit,
  output logic                stat_hit,
  output phycfg_sel_e         sel
);
  generate
    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_hit
      localparam logic [ADDR_W-1:0] RegAddr = ADDR_W'(i * 4);
      assign ctrl_hit[i] = (addr == RegAddr);
    end
  endgenerate

  assign stat_hit = (addr == STAT_ADDR);

  always_comb begin
    if (|ctrl_hit)     sel = SEL_CTRL;
    else if (stat_hit) sel = SEL_STAT;
    else               sel = SEL_NONE;
  end
endmodule

// File: rtl/phycfg_rdmux.sv
module phycfg_rdmux
  import phycfg_pkg::*;
#(
  parameter int HALF_W   = 16,
  parameter int NUM_CTRL = 7
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rd,
  input  phycfg_sel_e                sel,
  input  logic [NUM_CTRL-1:0]        ctrl_hit,
  input  logic [NUM_CTRL*HALF_W-1:0] ctrl_flat,
  input  logic [2*HALF_W-1:0]        stat_word,
  output logic [2*HALF_W-1:0]        rdata
);
  localparam int DataW = 2 * HALF_W;

  logic [HALF_W-1:0] ctrl_pick;
  logic [DataW-1:0]  next_word;

  always_comb begin
    ctrl_pick = '0;
    for (int i = 0; i < NUM_CTRL; i++) begin
      if (ctrl_hit[i]) ctrl_pick = ctrl_pick | ctrl_flat[i*HALF_W +: HALF_W];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL: next_word = {{HALF_W{1'b0}}, ctrl_pick};
      SEL_STAT: next_word = stat_word;
      default:  next_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= next_word;
  end

  // R4: read data holds between reads
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));
endmodule

// File: rtl/phycfg_regbank.sv
module phycfg_regbank
  import phycfg_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter int                HALF_W      = 16,
  parameter int                NUM_CTRL    = 7,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = 8'h20,
  parameter int                PWR_REG     = 6,
  parameter int                PWR_BIT     = 0,
  parameter int                DLL_BIT     = 1,
  parameter int                CAL_BIT     = 6,
  parameter int                RDY_BIT     = 5,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [2*HALF_W-1:0] bus_wdata,
  input  logic                bus_rd,
  output logic [2*HALF_W-1:0] bus_rdata,
  input  logic                cal_done_i,
  input  logic                dll_ready_i,
  output logic                pwr_on_o,
  output logic                dll_en_o
);
  localparam int DataW = 2 * HALF_W;
  localparam int FlatW = NUM_CTRL * HALF_W;

  logic [NUM_CTRL-1:0] ctrl_hit;
  logic                stat_hit;
  phycfg_sel_e         sel;
  logic [FlatW-1:0]    ctrl_flat;
  logic [1:0]          flags_sync;
  logic [DataW-1:0]    stat_word;

  phycfg_decode #(
    .ADDR_W(ADDR_W), .NUM_CTRL(NUM_CTRL), .STAT_ADDR(STAT_ADDR)
  ) u_decode (
    .addr(bus_addr), .ctrl_hit(ctrl_hit), .stat_hit(stat_hit), .sel(sel)
  );

  generate
    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_reg
      phycfg_mreg #(.HALF_W(HALF_W)) u_mreg (
        .clk(clk), .rst(rst),
        .we(bus_wr && ctrl_hit[i]),
        .wdata(bus_wdata),
        .q(ctrl_flat[i*HALF_W +: HALF_W])
      );
    end
  endgenerate

  phycfg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .async_i({cal_done_i, dll_ready_i}),
    .sync_o(flags_sync)
  );

  always_comb begin
    stat_word          = '0;
    stat_word[CAL_BIT] = flags_sync[1];
    stat_word[RDY_BIT] = flags_sync[0];
  end

  phycfg_rdmux #(.HALF_W(HALF_W), .NUM_CTRL(NUM_CTRL)) u_rdmux (
    .clk(clk), .rst(rst), .rd(bus_rd), .sel(sel),
    .ctrl_hit(ctrl_hit), .ctrl_flat(ctrl_flat),
    .stat_word(stat_word), .rdata(bus_rdata)
  );

  assign pwr_on_o = ctrl_flat[PWR_REG*HALF_W + PWR_BIT];
  assign dll_en_o = ctrl_flat[PWR_REG*HALF_W + DLL_BIT];

  // R7: writes outside the control range leave every register unchanged
  a_r7_ignored_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !(|ctrl_hit)) |=> $stable(ctrl_flat));
  // R4: control reads return zero in the upper half
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (|ctrl_hit)) |=> (bus_rdata[DataW-1:HALF_W] == '0));
  // R6: status reads carry only the two flag bits
  a_r6_status_bits: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && stat_hit) |=>
      ($countones(bus_rdata) == $countones({bus_rdata[CAL_BIT], bus_rdata[RDY_BIT]})));
  // R5: a masked write of the power bit reaches the output next cycle
  a_r5_pwr_follow: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && ctrl_hit[PWR_REG] && bus_wdata[HALF_W+PWR_BIT]) |=>
      (pwr_on_o == $past(bus_wdata[PWR_BIT])));
  // R5: a masked write of the DLL bit reaches the output next cycle
  a_r5_dll_follow: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && ctrl_hit[PWR_REG] && bus_wdata[HALF_W+DLL_BIT]) |=>
      (dll_en_o == $past(bus_wdata[DLL_BIT])));
endmodule

// File: tb/phycfg_regbank_bench.sv
module phycfg_regbank_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        cal_done_i = 1'b0;
  logic        dll_ready_i = 1'b0;
  logic        pwr_on_o;
  logic        dll_en_o;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    finished = 0;
  bit    started = 0;
  string cur_req = "R1";

  // reference model state
  logic [15:0] m_ctrl [7];
  logic [31:0] m_rdata = '0;
  logic        m_s1c = 0, m_s2c = 0, m_s1d = 0, m_s2d = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phycfg_regbank u_phycfg_regbank (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .cal_done_i(cal_done_i), .dll_ready_i(dll_ready_i),
    .pwr_on_o(pwr_on_o), .dll_en_o(dll_en_o)
  );

  function automatic logic [31:0] m_lookup(input logic [7:0] a);
    if (a[1:0] == 2'b00 && a <= 8'h18) return {16'h0, m_ctrl[a >> 2]};
    if (a == 8'h20) return {25'h0, m_s2c, m_s2d, 5'h0};
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 7; i++) m_ctrl[i] = '0;
      m_rdata = '0;
      m_s1c = 0; m_s2c = 0; m_s1d = 0; m_s2d = 0;
      started = 1;
    end else begin
      if (bus_rd) m_rdata = m_lookup(bus_addr);
      if (bus_wr && bus_addr[1:0] == 2'b00 && bus_addr <= 8'h18)
        for (int b = 0; b < 16; b++)
          if (bus_wdata[b+16]) m_ctrl[bus_addr >> 2][b] = bus_wdata[b];
      m_s2c = m_s1c; m_s1c = cal_done_i;
      m_s2d = m_s1d; m_s1d = dll_ready_i;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (started && !finished) begin
      chk({cur_req, " rdata"}, bus_rdata, m_rdata);
      chk("R5 pwr_on", {31'h0, pwr_on_o}, {31'h0, m_ctrl[6][0]});
      chk("R5 dll_en", {31'h0, dll_en_o}, {31'h0, m_ctrl[6][1]});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 0;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a; bus_rd = 1; bus_wr = 0;
    @(negedge clk);
    bus_rd = 0;
    v = bus_rdata;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R1";
    chk("R1 rdata", bus_rdata, 32'h0);
    chk("R1 pwr", {31'h0, pwr_on_o}, 32'h0);
    chk("R1 dll", {31'h0, dll_en_o}, 32'h0);
    rd(8'h18, v); chk("R1 reg18", v, 32'h0);

    cur_req = "R5";
    wr(8'h18, 32'h0001_0001);
    chk("R5 pwr on", {31'h0, pwr_on_o}, 32'h1);
    chk("R5 dll still off", {31'h0, dll_en_o}, 32'h0);

    cur_req = "R2";
    wr(8'h18, 32'h0002_FFFF);
    rd(8'h18, v); chk("R2 only bit1 set", v, 32'h0000_0003);
    wr(8'h18, 32'h0000_0000);
    rd(8'h18, v); chk("R2 empty mask", v, 32'h0000_0003);

    cur_req = "R3";
    for (int i = 0; i < 7; i++) wr(8'(i*4), 32'hFFFF_A5A0 + 32'(i));
    for (int i = 0; i < 7; i++) begin
      rd(8'(i*4), v); chk("R3 R4 map", v, 32'h0000_A5A0 + 32'(i));
    end
    wr(8'h00, 32'h00FF_0000);
    rd(8'h00, v); chk("R2 low byte cleared", v, 32'h0000_A500);

    cur_req = "R7";
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h1C, 32'hFFFF_0000);
    wr(8'h24, 32'hFFFF_0000);
    wr(8'h02, 32'hFFFF_0000);
    rd(8'h1C, v); chk("R7 unmapped read", v, 32'h0);
    rd(8'h00, v); chk("R7 reg0 intact", v, 32'h0000_A500);
    rd(8'h04, v); chk("R7 reg4 intact", v, 32'h0000_A5A1);
    rd(8'h20, v); chk("R7 status intact", v, 32'h0);

    cur_req = "R6";
    cal_done_i = 1;
    repeat (3) @(negedge clk);
    rd(8'h20, v); chk("R6 cal done", v, 32'h0000_0040);
    dll_ready_i = 1;
    repeat (3) @(negedge clk);
    rd(8'h20, v); chk("R6 both", v, 32'h0000_0060);
    cal_done_i = 0;
    rd(8'h20, v); chk("R6 same-cycle read sees old", v, 32'h0000_0060);
    @(negedge clk);
    rd(8'h20, v); chk("R6 after two edges", v, 32'h0000_0020);

    cur_req = "R8";
    bus_addr = 8'h08; bus_wdata = 32'hFFFF_1234; bus_wr = 1; bus_rd = 1;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    chk("R8 read-before-write", bus_rdata, 32'h0000_A5A2);
    rd(8'h08, v); chk("R8 new value", v, 32'h0000_1234);

    cur_req = "R2 R4 mixed";
    for (int k = 0; k < 400; k++) begin
      bus_addr    = ($urandom % 4 == 0) ? 8'($urandom % 40) : 8'(($urandom % 10) * 4);
      bus_wdata   = $urandom;
      bus_wr      = $urandom % 2;
      bus_rd      = $urandom % 2;
      cal_done_i  = $urandom % 2;
      dll_ready_i = $urandom % 2;
      @(negedge clk);
    end
    bus_wr = 0; bus_rd = 0;

    cur_req = "R1";
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R1 rdata after reset", bus_rdata, 32'h0);
    chk("R1 pwr after reset", {31'h0, pwr_on_o}, 32'h0);
    rd(8'h14, v); chk("R1 reg14 after reset", v, 32'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule